// File: doc/BRIEF.md
# Thirty-Two-Bit Arithmetic and Logic Unit with Set-Less-Than

This block is a purely combinational arithmetic and logic unit for a datapath. It takes two operands and a three-bit function code. It returns a result word together with a zero flag and a signed-overflow flag. The result and both flags settle within the same cycle as the inputs, with no register in the path.

The top bit of the function code serves two purposes. It inverts the second operand, and it also feeds the carry-in of the single shared adder. As a result, one adder produces both the sum and the difference. The lower two bits choose which result reaches the output: the bitwise AND, the bitwise OR, the adder sum, or the set-less-than word. The set-less-than word is built from the sign bit of the difference.

A parameter selects the adder structure: a ripple carry chain or a logarithmic-depth parallel-prefix tree. Both structures give identical results.

Top module: `alu32_core`

## Requirements
- R1: Function code 000 yields opa AND opb; code 001 yields opa OR opb.
- R2: Code 010 yields opa + opb, modulo 2^32.
- R3: Code 100 yields opa AND (NOT opb); code 101 yields opa OR (NOT opb).
- R4: Code 110 yields opa - opb, formed as opa + (NOT opb) + 1, where the +1 is the adder carry-in taken from code bit 2.
- R5: Code 111 yields bit 31 of opa + (NOT opb) + 1 in result bit 0, and zero in result bits 31..1. For example, opa=25 and opb=32 give 0x00000001.
- R6: Code 011 yields a result of zero.
- R7: zero_flag is 1 exactly when the 32-bit result is all zeros, for every code.
- R8: For codes 010 and 110, ovf_flag is 1 when the signed add or subtract leaves the 32-bit signed range. For every other code, ovf_flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand, inverted when code bit 2 is set |
| fn | input | 3 | Function code |
| res | output | 32 | Result word |
| zero_flag | output | 1 | Result equals zero |
| ovf_flag | output | 1 | Signed overflow of add or subtract |

## Verification
The zero flag and the overflow flag can both be raised by one add or subtract. For example, adding 0x80000000 to itself wraps to zero with a carry out of the top bit. Set-less-than also shares its adder with a subtract that overflows, in which case it reports the raw sign bit. The bench provokes these coincidences with directed operand pairs and with random draws that favour the signed extremes. It judges all three outputs against a model that detects overflow from operand and result signs rather than from carries.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    FN_AND  = 3'b000,
    FN_OR   = 3'b001,
    FN_ADD  = 3'b010,
    FN_RSVD = 3'b011,
    FN_ANDN = 3'b100,
    FN_ORN  = 3'b101,
    FN_SUB  = 3'b110,
    FN_SLT  = 3'b111
  } alu_fn_e;

  typedef enum logic [2:0] {
    SEL_AND,
    SEL_OR,
    SEL_SUM,
    SEL_SLT,
    SEL_ZERO
  } res_sel_e;

  localparam int unsigned ADDER_RIPPLE = 0;
  localparam int unsigned ADDER_PREFIX = 1;

endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
  import alu_pkg::*;
(
  input  logic [2:0] fn,
  output logic       inv_b,
  output logic       carry_in,
  output res_sel_e   sel,
  output logic       ovf_en
);

  always_comb begin
    inv_b    = fn[2];
    carry_in = fn[2];
    ovf_en   = 1'b0;
    sel      = SEL_ZERO;
    unique case (alu_fn_e'(fn))
      FN_AND, FN_ANDN: sel = SEL_AND;
      FN_OR,  FN_ORN:  sel = SEL_OR;
      FN_ADD, FN_SUB: begin
        sel    = SEL_SUM;
        ovf_en = 1'b1;
      end
      FN_SLT:  sel = SEL_SLT;
      FN_RSVD: sel = SEL_ZERO;
      default: sel = SEL_ZERO;
    endcase
  end

  // R8
  always_comb begin
    ovf_scope_chk: assert (!ovf_en || (fn[1:0] == 2'b10))
      else $error("overflow enabled outside add/sub");
  end

endmodule

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opb,
  input  logic             inv_b,
  output logic [WIDTH-1:0] opb_eff
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_inv
    assign opb_eff[i] = opb[i] ^ inv_b;
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned KIND  = ADDER_PREFIX
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_msb_in,
  output logic             c_out
);

  localparam int unsigned STAGES = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int unsigned XW     = WIDTH + 1;

  logic [WIDTH-1:0] gen_b;
  logic [WIDTH-1:0] prop_b;
  logic [WIDTH:0]   carry;

  assign gen_b    = a & b;
  assign prop_b   = a ^ b;
  assign carry[0] = cin;

  if (KIND == ADDER_RIPPLE) begin : g_ripple
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign carry[i+1] = gen_b[i] | (prop_b[i] & carry[i]);
    end
  end else begin : g_prefix
    logic [WIDTH-1:0] gk [STAGES+1];
    logic [WIDTH-1:0] pk [STAGES+1];
    assign gk[0] = gen_b;
    assign pk[0] = prop_b;
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int unsigned SPAN = 1 << s;
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        if (i >= SPAN) begin : g_black
          assign gk[s+1][i] = gk[s][i] | (pk[s][i] & gk[s][i-SPAN]);
          assign pk[s+1][i] = pk[s][i] & pk[s][i-SPAN];
        end else begin : g_pass
          assign gk[s+1][i] = gk[s][i];
          assign pk[s+1][i] = pk[s][i];
        end
      end
    end
    for (genvar i = 0; i < WIDTH; i++) begin : g_carry
      assign carry[i+1] = gk[STAGES][i] | (pk[STAGES][i] & cin);
    end
  end

  assign sum      = prop_b ^ carry[WIDTH-1:0];
  assign c_msb_in = carry[WIDTH-1];
  assign c_out    = carry[WIDTH];

  // R2
  always_comb begin
    adder_sum_chk: assert ({c_out, sum} ==
                           (XW'(a) + XW'(b) + XW'(cin)))
      else $error("adder disagrees with arithmetic sum");
  end

endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  res_sel_e         sel,
  input  logic [WIDTH-1:0] and_v,
  input  logic [WIDTH-1:0] or_v,
  input  logic [WIDTH-1:0] sum_v,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    res = '0;
    unique case (sel)
      SEL_AND:  res = and_v;
      SEL_OR:   res = or_v;
      SEL_SUM:  res = sum_v;
      SEL_SLT:  res = {{(WIDTH-1){1'b0}}, sum_v[WIDTH-1]};
      SEL_ZERO: res = '0;
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH      = 32,
  parameter int unsigned ADDER_KIND = ADDER_PREFIX
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       fn,
  output logic [WIDTH-1:0] res,
  output logic             zero_flag,
  output logic             ovf_flag
);

  logic             inv_b;
  logic             carry_in;
  logic             ovf_en;
  res_sel_e         sel;
  logic [WIDTH-1:0] opb_eff;
  logic [WIDTH-1:0] sum_v;
  logic             c_msb_in;
  logic             c_out;

  alu_fn_decode u_dec (
    .fn       (fn),
    .inv_b    (inv_b),
    .carry_in (carry_in),
    .sel      (sel),
    .ovf_en   (ovf_en)
  );

  alu_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .opb     (opb),
    .inv_b   (inv_b),
    .opb_eff (opb_eff)
  );

  alu_adder #(.WIDTH(WIDTH), .KIND(ADDER_KIND)) u_add (
    .a        (opa),
    .b        (opb_eff),
    .cin      (carry_in),
    .sum      (sum_v),
    .c_msb_in (c_msb_in),
    .c_out    (c_out)
  );

  alu_result_mux #(.WIDTH(WIDTH)) u_mux (
    .sel   (sel),
    .and_v (opa & opb_eff),
    .or_v  (opa | opb_eff),
    .sum_v (sum_v),
    .res   (res)
  );

  assign zero_flag = ~|res;
  assign ovf_flag  = ovf_en & (c_out ^ c_msb_in);

  always_comb begin
    // R4
    sub_result_chk: assert (fn != 3'b110 || res == opa - opb)
      else $error("subtract result mismatch");
    // R5
    slt_upper_chk: assert (fn != 3'b111 || res[WIDTH-1:1] == '0)
      else $error("set-less-than upper bits not zero");
    // R6
    rsvd_zero_chk: assert (fn != 3'b011 || (res == '0 && zero_flag))
      else $error("reserved code produced nonzero result");
    // R8
    no_overflow_chk: assert (fn[1:0] == 2'b10 || !ovf_flag)
      else $error("overflow flag raised outside add/sub");
  end

endmodule

// File: tb/alu32_core_tb.sv
module alu32_core_tb_top;

  logic        clk;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [2:0]  fn;
  logic [31:0] res;
  logic        zero_flag;
  logic        ovf_flag;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  alu32_core dut_i (
    .opa       (opa),
    .opb       (opb),
    .fn        (fn),
    .res       (res),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string fn_tag(input logic [2:0] f);
    case (f)
      3'b000, 3'b001: return "R1";
      3'b010:         return "R2";
      3'b100, 3'b101: return "R3";
      3'b110:         return "R4";
      3'b111:         return "R5";
      default:        return "R6";
    endcase
  endfunction

  function automatic logic [31:0] ref_res(input logic [31:0] a, b, input logic [2:0] f);
    logic [31:0] d;
    d = a - b;
    case (f)
      3'b000: return a & b;
      3'b001: return a | b;
      3'b010: return a + b;
      3'b100: return a & ~b;
      3'b101: return a | ~b;
      3'b110: return d;
      3'b111: return {31'd0, d[31]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic ref_ovf(input logic [31:0] a, b, input logic [2:0] f);
    logic [31:0] s;
    if (f == 3'b010) begin
      s = a + b;
      return (a[31] == b[31]) && (s[31] != a[31]);
    end else if (f == 3'b110) begin
      s = a - b;
      return (a[31] != b[31]) && (s[31] != a[31]);
    end
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] f);
    logic [31:0] er;
    @(negedge clk);
    opa = a;
    opb = b;
    fn  = f;
    #2;
    er = ref_res(a, b, f);
    check(fn_tag(f), res, er);
    check("R7", {31'd0, zero_flag}, {31'd0, er == 32'd0});
    check("R8", {31'd0, ovf_flag}, {31'd0, ref_ovf(a, b, f)});
  endtask

  function automatic logic [31:0] pick_operand();
    case ($urandom_range(5, 0))
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED_0140);
    opa = '0;
    opb = '0;
    fn  = 3'b000;
    @(negedge clk);
    #2;
    // initial state: zero inputs, AND code -> zero result, zero flag set
    check("R1", res, 32'd0);
    check("R7", {31'd0, zero_flag}, 32'd1);

    // R5 directed: 25 < 32 -> 1, 32 vs 25 -> 0
    apply(32'd25, 32'd32, 3'b111);
    check("R5", res, 32'h0000_0001);
    apply(32'd32, 32'd25, 3'b111);
    apply(32'd7, 32'd7, 3'b111);
    // R4 carry-in completes the negation: A - 0 = A, 0 - 1 = all ones
    apply(32'h1234_5678, 32'd0, 3'b110);
    apply(32'd0, 32'd1, 3'b110);
    apply(32'd9, 32'd9, 3'b110);
    // R2 with R7 and R8 together: wrap to zero with overflow
    apply(32'h8000_0000, 32'h8000_0000, 3'b010);
    apply(32'h7FFF_FFFF, 32'd1, 3'b010);
    apply(32'hFFFF_FFFF, 32'd1, 3'b010);
    // R4 overflow, and R5 reporting the raw sign bit of that difference
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
    apply(32'h8000_0000, 32'd1, 3'b111);
    // R1 and R3 with operands that would overflow: no flag
    apply(32'h8000_0000, 32'h8000_0000, 3'b000);
    apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b001);
    apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b100);
    apply(32'h0000_0000, 32'hFFFF_FFFF, 3'b101);
    // R6: unused code ignores operands
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
    apply(32'h8000_0000, 32'h8000_0000, 3'b011);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      logic [2:0]  rf;
      ra = pick_operand();
      rb = pick_operand();
      rf = 3'($urandom_range(7, 0));
      apply(ra, rb, rf);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule